// File: doc/BRIEF.md
# RTC Periodic Interrupt and Flag Unit

This unit produces the periodic interrupt of a real-time clock and holds the clock's interrupt status byte. A timebase enable pulse, `osc_en`, feeds a prescaler that turns the selected oscillator into 32768 Hz steps. A period counter then divides those steps down by an amount set by a 4-bit rate code. Each period that ends adds one to a saturating count of pending ticks. While the periodic enable is set, the interrupt stays asserted for as long as any tick remains unacknowledged.

Software writes two control bytes through one write port. Configuration A holds the rate code and the divider code. Configuration B holds the three interrupt enables. Software reads the status byte through a read strobe. A read returns the byte and clears it, which acknowledges one pending tick. The time-of-day counters and the alarm comparator are outside this unit. They report through the single-cycle inputs `upd_evt` and `alm_evt`.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After a synchronous reset, `irq` is 0, `stat_data` is 0x00, the status byte reads 0x00 and no tick is pending. Configuration A resets to rate 0 and divider 0b000; configuration B resets to all enables cleared.
- R2: Rate code 0 (configuration A bits 3:0) produces no periodic tick, whatever the divider code.
- R3: With divider code 0b010 (configuration A bits 6:4, 32 kHz timebase), one step is PRE_32K pulses of `osc_en`. The period is 128 steps for rate 1, 256 steps for rate 2, and 2^(n-1) steps for any rate n from 3 to 15.
- R4: Divider code 0b001 selects 1 MHz, where one step is PRE_1M pulses of `osc_en`. Divider code 0b000 selects 4 MHz, where one step is PRE_4M pulses. With either of these, rates 1 and 2 give periods of 1 and 2 steps, and rates 3 to 15 give the same periods as in R3.
- R5: Divider codes 0b011 to 0b111 stop the prescaler and the period counter, so no tick occurs.
- R6: A write to configuration A (`wr_sel`=0) stores only bits 6:0, so bit 7 has no effect. The write also restarts the prescaler and the period counter from zero.
- R7: Every tick adds one to the pending count, which holds at 2^PEND_W-1 instead of wrapping.
- R8: When configuration B bit 6 (periodic enable) is set and the pending count is nonzero, the periodic flag (status bit 6) is set and `irq` is asserted on the next clock edge.
- R9: A pulse on `upd_evt` sets status bit 4 and a pulse on `alm_evt` sets status bit 5. Status bit 7 is set whenever bit 4, 5 or 6 is set. Status bits 3:0 always read 0.
- R10: A pulse on `rd_stat` loads the current status byte into `stat_data` and clears the byte, except for update or alarm events that arrive in the same cycle. It also deasserts `irq`. If the periodic flag was set and ticks are pending, the pending count drops by one.
- R11: A write to configuration B (`wr_sel`=1) with bit 6 clear deasserts `irq` on the next edge.
- R12: Configuration B bit 4 (update enable) with status bit 4 set, or bit 5 (alarm enable) with status bit 5 set, also asserts `irq`. Once asserted, `irq` stays high until R10 or R11 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | One pulse per cycle of the selected timebase oscillator |
| wr_en | input | 1 | Control write strobe |
| wr_sel | input | 1 | Write target: 0 for configuration A, 1 for configuration B |
| wr_data | input | 8 | Write data byte |
| rd_stat | input | 1 | Status read strobe; clears the status byte |
| upd_evt | input | 1 | Update-ended event pulse |
| alm_evt | input | 1 | Alarm-match event pulse |
| irq | output | 1 | Registered level interrupt request |
| stat_data | output | 8 | Status byte captured by the last read |

## Verification
The assertions expect a single-cycle strobe on `rd_stat` and on `wr_en`, and they expect `upd_evt` and `alm_evt` to be synchronous one-cycle pulses. They do not constrain `osc_en`, so the prescaler can see any pattern of enables. The stimulus drives every strobe for exactly one cycle after a clock edge. It writes configuration A only with divider codes from the legal set or from the stopped set. It runs `osc_en` always high, always low, or from a deterministic pseudo-random pattern. Reads, writes and events are allowed to coincide in the same cycle.

// File: rtl/rtc_pi_pkg.sv
package rtc_pi_pkg;

  localparam int PER_W = 15;

  // status byte bit positions
  localparam int ST_IRQF = 7;
  localparam int ST_PF   = 6;
  localparam int ST_AF   = 5;
  localparam int ST_UF   = 4;

  // configuration B enable positions
  localparam int EN_PIE = 6;
  localparam int EN_AIE = 5;
  localparam int EN_UIE = 4;

  typedef enum logic [1:0] {
    TB_FAST4 = 2'd0,
    TB_FAST1 = 2'd1,
    TB_SLOW  = 2'd2,
    TB_HALT  = 2'd3
  } tbase_e;

  function automatic tbase_e decode_div(input logic [2:0] code);
    case (code)
      3'b000:  return TB_FAST4;
      3'b001:  return TB_FAST1;
      3'b010:  return TB_SLOW;
      default: return TB_HALT;
    endcase
  endfunction

  // Period in 32768 Hz steps; zero means no tick.
  function automatic logic [PER_W-1:0] period_steps(input logic [3:0] rate,
                                                    input logic       slow);
    logic [PER_W-1:0] one;
    one = PER_W'(1);
    case (rate)
      4'd0:    return '0;
      4'd1:    return slow ? PER_W'(128) : PER_W'(1);
      4'd2:    return slow ? PER_W'(256) : PER_W'(2);
      default: return one << (rate - 4'd1);
    endcase
  endfunction

endpackage

// File: rtl/rtc_pi_divider.sv
module rtc_pi_divider
  import rtc_pi_pkg::*;
#(
  parameter int PRE_32K = 1,
  parameter int PRE_1M  = 31,
  parameter int PRE_4M  = 122
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_en,
  input  logic       cfg_wr,
  input  logic [3:0] rate,
  input  logic [2:0] div,
  output logic       tick
);

  localparam int PRE_MAX = (PRE_4M > PRE_1M) ? ((PRE_4M > PRE_32K) ? PRE_4M : PRE_32K)
                                             : ((PRE_1M > PRE_32K) ? PRE_1M : PRE_32K);
  localparam int PRE_W = $clog2(PRE_MAX + 1);

  tbase_e           tb;
  logic [PRE_W-1:0] pre_lim;
  logic [PRE_W-1:0] pre_cnt;
  logic [PER_W-1:0] per_lim;
  logic [PER_W-1:0] per_cnt;
  logic             halted;
  logic             pre_last;
  logic             per_last;

  always_comb begin
    tb = decode_div(div);
    case (tb)
      TB_FAST4: pre_lim = PRE_W'(PRE_4M);
      TB_FAST1: pre_lim = PRE_W'(PRE_1M);
      TB_SLOW:  pre_lim = PRE_W'(PRE_32K);
      default:  pre_lim = '0;
    endcase
    per_lim  = period_steps(rate, tb == TB_SLOW);
    halted   = (tb == TB_HALT) || (per_lim == '0);
    pre_last = (pre_cnt == pre_lim - PRE_W'(1));
    per_last = (per_cnt == per_lim - PER_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_wr || halted) begin
      pre_cnt <= '0;
      per_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (osc_en) begin
        if (pre_last) begin
          pre_cnt <= '0;
          if (per_last) begin
            per_cnt <= '0;
            tick    <= 1'b1;
          end else begin
            per_cnt <= per_cnt + PER_W'(1);
          end
        end else begin
          pre_cnt <= pre_cnt + PRE_W'(1);
        end
      end
    end
  end

  // R2
  idle_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (rate == 4'd0) |=> !tick);

  // R5
  halt_div_chk: assert property (@(posedge clk) disable iff (rst)
    (div > 3'b010) |=> !tick);

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> !tick);

endmodule

// File: rtl/rtc_pi_pending.sv
module rtc_pi_pending #(
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              dec,
  output logic [PEND_W-1:0] count,
  output logic              nonzero
);

  localparam logic [PEND_W-1:0] FULL = {PEND_W{1'b1}};

  assign nonzero = (count != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (count != FULL) count <= count + PEND_W'(1);
        2'b01:   if (nonzero)       count <= count - PEND_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (count == FULL && inc && !dec) |=> (count == FULL));

  // R7
  no_loss_chk: assert property (@(posedge clk) disable iff (rst)
    !dec |=> (count >= $past(count)));

endmodule

// File: rtl/rtc_pi_status.sv
module rtc_pi_status
  import rtc_pi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_b,
  input  logic [7:0] wdata,
  input  logic       rd_c,
  input  logic       upd_in,
  input  logic       alm_in,
  input  logic       pend_nz,
  output logic       pf_ack,
  output logic       irq,
  output logic [7:0] rd_data
);

  logic pie_q, aie_q, uie_q;
  logic pf_q, af_q, uf_q, irqf_q;
  logic pf_n, af_n, uf_n;
  logic irq_set, irq_clr, pie_off;

  assign pie_off = wr_b && !wdata[EN_PIE];
  assign pf_ack  = rd_c && pf_q;
  assign irq_set = (pie_q && pend_nz) || (uie_q && uf_q) || (aie_q && af_q);
  assign irq_clr = rd_c || pie_off;

  always_comb begin
    if (rd_c) begin
      pf_n = 1'b0;
      uf_n = upd_in;
      af_n = alm_in;
    end else begin
      pf_n = pf_q || (pie_q && pend_nz);
      uf_n = uf_q || upd_in;
      af_n = af_q || alm_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pie_q   <= 1'b0;
      aie_q   <= 1'b0;
      uie_q   <= 1'b0;
      pf_q    <= 1'b0;
      af_q    <= 1'b0;
      uf_q    <= 1'b0;
      irqf_q  <= 1'b0;
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_b) begin
        pie_q <= wdata[EN_PIE];
        aie_q <= wdata[EN_AIE];
        uie_q <= wdata[EN_UIE];
      end
      pf_q   <= pf_n;
      af_q   <= af_n;
      uf_q   <= uf_n;
      irqf_q <= pf_n || af_n || uf_n;
      irq    <= irq_clr ? 1'b0 : (irq || irq_set);
      if (rd_c) rd_data <= {irqf_q, pf_q, af_q, uf_q, 4'b0000};
    end
  end

  // R8
  pf_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (pie_q && pend_nz && !irq_clr) |=> (pf_q && irq));

  // R9
  upd_flag_chk: assert property (@(posedge clk) disable iff (rst)
    upd_in |=> (uf_q && irqf_q));

  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_c |=> (!pf_q && !irq));

  // R11
  pie_off_chk: assert property (@(posedge clk) disable iff (rst)
    pie_off |=> !irq);

endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq #(
  parameter int PRE_32K = 1,
  parameter int PRE_1M  = 31,
  parameter int PRE_4M  = 122,
  parameter int PEND_W  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_en,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_stat,
  input  logic       upd_evt,
  input  logic       alm_evt,
  output logic       irq,
  output logic [7:0] stat_data
);

  logic [3:0]        rate_q;
  logic [2:0]        div_q;
  logic              cfg_wr;
  logic              tick;
  logic              pf_ack;
  logic              pend_nz;
  logic [PEND_W-1:0] pend_cnt;

  assign cfg_wr = wr_en && !wr_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      div_q  <= '0;
    end else if (cfg_wr) begin
      rate_q <= wr_data[3:0];
      div_q  <= wr_data[6:4];
    end
  end

  rtc_pi_divider #(
    .PRE_32K (PRE_32K),
    .PRE_1M  (PRE_1M),
    .PRE_4M  (PRE_4M)
  ) u_div (
    .clk    (clk),
    .rst    (rst),
    .osc_en (osc_en),
    .cfg_wr (cfg_wr),
    .rate   (rate_q),
    .div    (div_q),
    .tick   (tick)
  );

  rtc_pi_pending #(
    .PEND_W (PEND_W)
  ) u_pend (
    .clk     (clk),
    .rst     (rst),
    .inc     (tick),
    .dec     (pf_ack),
    .count   (pend_cnt),
    .nonzero (pend_nz)
  );

  rtc_pi_status u_stat (
    .clk     (clk),
    .rst     (rst),
    .wr_b    (wr_en && wr_sel),
    .wdata   (wr_data),
    .rd_c    (rd_stat),
    .upd_in  (upd_evt),
    .alm_in  (alm_evt),
    .pend_nz (pend_nz),
    .pf_ack  (pf_ack),
    .irq     (irq),
    .rd_data (stat_data)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!irq && stat_data == 8'h00 && pend_cnt == '0));

endmodule

// File: tb/rtc_periodic_irq_tb.sv
module rtc_periodic_irq_tb;

  localparam int P32 = 1;
  localparam int P1M = 3;
  localparam int P4M = 5;
  localparam int PMAX = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_stat = 1'b0;
  logic       upd_evt = 1'b0;
  logic       alm_evt = 1'b0;
  logic       irq;
  logic [7:0] stat_data;

  always #2 clk = ~clk;

  rtc_periodic_irq #(
    .PRE_32K (P32), .PRE_1M (P1M), .PRE_4M (P4M), .PEND_W (4)
  ) u_dut (
    .clk (clk), .rst (rst), .osc_en (osc_en), .wr_en (wr_en),
    .wr_sel (wr_sel), .wr_data (wr_data), .rd_stat (rd_stat),
    .upd_evt (upd_evt), .alm_evt (alm_evt), .irq (irq), .stat_data (stat_data)
  );

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  int osc_mode = 0;
  int lcg = 12345;

  // behavioural reference state
  int m_rate, m_div, m_b, m_pre, m_per, m_tick, m_pend;
  int m_pf, m_af, m_uf, m_irqf, m_irq, m_rd;

  function automatic int plim_of(input int d);
    if (d == 2) return P32;
    if (d == 1) return P1M;
    if (d == 0) return P4M;
    return 0;
  endfunction

  function automatic int perlim_of(input int r, input int d);
    if (r == 0) return 0;
    if (r == 1) return (d == 2) ? 128 : 1;
    if (r == 2) return (d == 2) ? 256 : 2;
    return 1 << (r - 1);
  endfunction

  always @(posedge clk) begin
    int n_pre, n_per, n_tick, n_pend, n_pf, n_af, n_uf, n_irq, pl, rl, dec, set, clr;
    if (rst) begin
      m_rate = 0; m_div = 0; m_b = 0; m_pre = 0; m_per = 0; m_tick = 0; m_pend = 0;
      m_pf = 0; m_af = 0; m_uf = 0; m_irqf = 0; m_irq = 0; m_rd = 0;
    end else begin
      pl = plim_of(m_div);
      rl = perlim_of(m_rate, m_div);
      n_pre = m_pre; n_per = m_per; n_tick = 0;
      if ((wr_en && !wr_sel) || pl == 0 || rl == 0) begin
        n_pre = 0; n_per = 0;
      end else if (osc_en) begin
        if (m_pre == pl - 1) begin
          n_pre = 0;
          if (m_per == rl - 1) begin n_per = 0; n_tick = 1; end
          else n_per = m_per + 1;
        end else n_pre = m_pre + 1;
      end
      dec = (rd_stat && m_pf && m_pend > 0) ? 1 : 0;
      n_pend = m_pend + m_tick - dec;
      if (n_pend > PMAX) n_pend = PMAX;
      if (rd_stat) begin
        m_rd = (m_irqf << 7) | (m_pf << 6) | (m_af << 5) | (m_uf << 4);
        n_pf = 0; n_uf = upd_evt; n_af = alm_evt;
      end else begin
        n_pf = (m_pf || (((m_b >> 6) & 1) && m_pend > 0)) ? 1 : 0;
        n_uf = (m_uf || upd_evt) ? 1 : 0;
        n_af = (m_af || alm_evt) ? 1 : 0;
      end
      set = ((((m_b >> 6) & 1) && m_pend > 0) || (((m_b >> 4) & 1) && m_uf) ||
             (((m_b >> 5) & 1) && m_af)) ? 1 : 0;
      clr = (rd_stat || (wr_en && wr_sel && !wr_data[6])) ? 1 : 0;
      n_irq = clr ? 0 : ((m_irq || set) ? 1 : 0);
      if (wr_en && wr_sel) m_b = wr_data;
      if (wr_en && !wr_sel) begin m_rate = wr_data & 15; m_div = (wr_data >> 4) & 7; end
      m_pre = n_pre; m_per = n_per; m_tick = n_tick; m_pend = n_pend;
      m_pf = n_pf; m_af = n_af; m_uf = n_uf; m_irqf = (n_pf || n_af || n_uf) ? 1 : 0;
      m_irq = n_irq;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if (irq !== m_irq[0]) begin
        miscompares++;
        $display("FAIL %s irq actual=%0b expected=%0d at cycle %0d", cur_req, irq, m_irq, cycles);
      end
      vectors++;
      if (stat_data !== m_rd[7:0]) begin
        miscompares++;
        $display("FAIL %s stat_data actual=%02h expected=%02h at cycle %0d",
                 cur_req, stat_data, m_rd[7:0], cycles);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=%0d cycles expected=finish", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic step(input bit w, input bit s, input logic [7:0] d,
                      input bit rd, input bit up, input bit al);
    wr_en = w; wr_sel = s; wr_data = d; rd_stat = rd; upd_evt = up; alm_evt = al;
    lcg = lcg * 1103515245 + 12345;
    osc_en = (osc_mode == 1) ? 1'b1 : (osc_mode == 2) ? lcg[17] : 1'b0;
    @(posedge clk); #1;
    wr_en = 0; rd_stat = 0; upd_evt = 0; alm_evt = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, 0, 0);
  endtask

  task automatic wa(input logic [7:0] d); step(1, 0, d, 0, 0, 0); endtask
  task automatic wb(input logic [7:0] d); step(1, 1, d, 0, 0, 0); endtask
  task automatic rdc(); step(0, 0, 8'h00, 1, 0, 0); endtask

  task automatic run_reads(input int n, input int gap);
    for (int i = 0; i < n; i++) begin idle(gap); rdc(); end
  endtask

  initial begin
    logic [7:0] alist [6];
    alist[0] = 8'h21; alist[1] = 8'h13; alist[2] = 8'h05;
    alist[3] = 8'h24; alist[4] = 8'h30; alist[5] = 8'h00;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state, then a read of the cleared status byte
    cur_req = "R1"; idle(3); rdc(); idle(2);

    // R2: rate zero, periodic enable on, oscillator running
    cur_req = "R2"; osc_mode = 1; wb(8'h40); wa(8'h20); idle(200); rdc(); idle(2);
    wa(8'h00); idle(50);

    // R3: 32 kHz timebase rate codes
    cur_req = "R3";
    wa(8'h21); run_reads(8, 60);
    wa(8'h22); run_reads(6, 100);
    wa(8'h23); run_reads(10, 5);
    wa(8'h27); run_reads(6, 40);
    osc_mode = 2; wa(8'h24); run_reads(10, 13); osc_mode = 1;
    wa(8'h2F); idle(16400); run_reads(3, 2);

    // R4: fast timebases
    cur_req = "R4";
    wa(8'h11); run_reads(12, 4);
    wa(8'h02); run_reads(12, 7);
    wa(8'h05); run_reads(8, 30);
    wa(8'h12); run_reads(8, 6);

    // R5: stopped divider codes
    cur_req = "R5";
    wa(8'h31); run_reads(20, 3); idle(200); rdc(); idle(3);
    wa(8'h71); idle(200); rdc(); idle(3);

    // R6: bit 7 of configuration A ignored, rewrite restarts the chain
    cur_req = "R6";
    wa(8'hA3); run_reads(6, 5);
    wa(8'h24); idle(5); wa(8'h24); idle(5); wa(8'h24); run_reads(6, 9);

    // R7: saturation then drain
    cur_req = "R7";
    wb(8'h00); wa(8'h11); idle(200); wa(8'h10); wb(8'h40);
    run_reads(20, 2); idle(5);

    // R8: pending tick raises flag and interrupt
    cur_req = "R8"; wa(8'h12); idle(12); wa(8'h10); idle(4); run_reads(4, 3);

    // R9: event flags and summary bit
    cur_req = "R9"; wb(8'h00);
    step(0, 0, 8'h00, 0, 1, 0); idle(2); rdc(); idle(2);
    step(0, 0, 8'h00, 0, 0, 1); idle(2); rdc(); idle(2);

    // R10: read coinciding with events keeps the new events
    cur_req = "R10";
    step(0, 0, 8'h00, 0, 1, 0); step(0, 0, 8'h00, 1, 0, 1); idle(1); rdc(); idle(2);

    // R11: clearing periodic enable drops the interrupt
    cur_req = "R11"; wb(8'h40); wa(8'h11); idle(20); wb(8'h00); idle(3); wb(8'h40); idle(3);
    wb(8'h50); idle(2); wa(8'h10); run_reads(20, 1);

    // R12: update and alarm enables
    cur_req = "R12"; wb(8'h10); step(0, 0, 8'h00, 0, 1, 0); idle(4); rdc(); idle(3);
    wb(8'h20); step(0, 0, 8'h00, 0, 0, 1); idle(4); wb(8'h20); idle(3); rdc(); idle(3);

    // mixed traffic
    cur_req = "R10";
    osc_mode = 2;
    for (int i = 0; i < 4000; i++) begin
      lcg = lcg * 1103515245 + 12345;
      case (lcg[20:17])
        4'd0:    wa(alist[lcg[26:24] % 6]);
        4'd1:    wb({1'b0, lcg[23:21], 4'b0000});
        4'd2, 4'd3: rdc();
        4'd4:    step(0, 0, 8'h00, lcg[22], 1, 0);
        4'd5:    step(0, 0, 8'h00, lcg[22], 0, 1);
        default: idle(1);
      endcase
    end
    idle(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule